// File: doc/BRIEF.md
# Stacked Clear-on-Read DMA Interrupt Status

This block gathers single-cycle event pulses from a bus-master controller and turns them into sticky status bits. The events come from the DMA engine, the bus interface and the script sequencer. A read strobe returns the visible bits and clears them in the same cycle. Each source has its own qualifier. Parity errors count only when master parity checking is on. Bus faults count only while the controller owns the bus. Step completions count only in single-step mode. A compare of both data and phase is illegal only in target mode.

Clearing on read can lose events, so a second pending stage is kept behind the visible register. An event is parked in that stage in two cases: when its bit is already set, or when it arrives inside the settle window that follows every read. When the window closes, the parked bits move into the visible register. The top bit of the read data shows the live FIFO-empty level and never takes part in interrupts. A write port loads an enable mask. Enabled visible bits drive a registered interrupt output and a sticky summary flag, and a read clears that flag.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, `rdata_o` is 0x80, and `irq_o` and `pend_o` are 0.
- R2: Read data layout, LSB first: bit 0 illegal instruction, 1 extended parity, 2 script interrupt, 3 single step, 4 abort, 5 bus fault, 6 master parity, 7 FIFO empty. `rdata_o` is updated one cycle after `rd_i` and holds between reads. Bit 7 is the value of `fifo_empty_i` sampled at the read.
- R3: A read clears every visible status bit. A read issued on the very next cycle returns 0 in bits 6:0.
- R4: After each read there is a settle window of SETTLE cycles (default 12). Events captured in that window do not appear at once. They become visible at the clock edge SETTLE cycles after the read edge.
- R5: An event whose bit is already set is kept in the pending stage. It becomes visible again once a read has cleared the bit and the settle window has closed.
- R6: Bit 6 sets on `data_perr_i` or `tgt_perr_i`, and only while `par_chk_en_i` is 1.
- R7: Bit 5 sets on `bad_addr_i` or `tgt_abort_i`, and only while `bus_master_i` is 1.
- R8: Bit 4 sets on `abort_cmd_i`. Bit 3 sets on `instr_done_i`, and only while `step_mode_i` is 1.
- R9: Bit 0 sets on `bad_opcode_i`, `zero_len_move_i` or `wait_req_nodisc_i`. It also sets on `cmp_both_i` when `target_mode_i` is 1.
- R10: Bit 1 sets on `ext_perr_i` when the parameter EXT_PAR is 1. Bit 2 sets on `int_instr_i`.
- R11: `irq_o` is 1 exactly when some visible bit in 6:0 is set together with its enable bit. It rises on the same edge that sets the status bit. Enable bit 7 has no effect.
- R12: `pend_o` sets under the same condition as `irq_o`. It stays set if the mask is cleared later, and a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty_i | input | 1 | Live FIFO-empty level |
| data_perr_i | input | 1 | Detected data parity error pulse |
| tgt_perr_i | input | 1 | Target-signalled parity error pulse |
| par_chk_en_i | input | 1 | Master parity checking enable |
| bad_addr_i | input | 1 | Cycle ended with bad address |
| tgt_abort_i | input | 1 | Cycle ended with target abort |
| bus_master_i | input | 1 | Controller currently owns the bus |
| abort_cmd_i | input | 1 | Software abort command pulse |
| instr_done_i | input | 1 | Instruction completed pulse |
| step_mode_i | input | 1 | Single-step mode enabled |
| int_instr_i | input | 1 | Interrupt instruction evaluated true |
| ext_perr_i | input | 1 | Extra parity pin error pulse |
| bad_opcode_i | input | 1 | Reserved opcode seen |
| zero_len_move_i | input | 1 | Block move with zero byte count |
| wait_req_nodisc_i | input | 1 | REQ during wait-disconnect without disconnect |
| cmp_both_i | input | 1 | Transfer control with compare data and phase set |
| target_mode_i | input | 1 | Controller in target mode |
| ien_wr_i | input | 1 | Enable mask write strobe |
| ien_wdata_i | input | 8 | Enable mask write data |
| rd_i | input | 1 | Status read strobe |
| rdata_o | output | 8 | Status read data |
| irq_o | output | 1 | Interrupt request |
| pend_o | output | 1 | Sticky summary pending flag |

## Verification
The hardest case to reach from the ports is an event that has to be parked in the pending stage and must not show until a precise edge. This happens when a source fires while its bit is already set, or inside the window after a read. The stimulus sets a bit, fires the same source again, and reads. It then counts edges and checks that the interrupt stays low for SETTLE-1 cycles and rises exactly at the SETTLE-th. A second case fires a source just after a read, inside the window. A sweep over all enable masks and many status patterns then checks the interrupt combination and the read data arithmetically.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NSRC = 7;
  localparam int B_ILL = 0;
  localparam int B_XPAR = 1;
  localparam int B_SCR = 2;
  localparam int B_STEP = 3;
  localparam int B_ABRT = 4;
  localparam int B_BFLT = 5;
  localparam int B_MPAR = 6;

  typedef struct packed {
    logic data_perr;
    logic tgt_perr;
    logic par_chk_en;
    logic bad_addr;
    logic tgt_abort;
    logic bus_master;
    logic abort_cmd;
    logic instr_done;
    logic step_mode;
    logic int_instr;
    logic ext_perr;
    logic bad_opcode;
    logic zero_len_move;
    logic wait_req_nodisc;
    logic cmp_both;
    logic target_mode;
  } raw_ev_t;
endpackage

// File: rtl/dma_irq_srcmap.sv
module dma_irq_srcmap
  import dma_irq_pkg::*;
#(
  parameter bit EXT_PAR = 1'b1
) (
  input  raw_ev_t          raw,
  output logic [NSRC-1:0]  ev
);
  logic ill_any;

  always_comb begin
    ill_any = raw.bad_opcode | raw.zero_len_move | raw.wait_req_nodisc
            | (raw.cmp_both & raw.target_mode);
  end

  assign ev[B_ILL]  = ill_any;
  assign ev[B_SCR]  = raw.int_instr;
  assign ev[B_STEP] = raw.instr_done & raw.step_mode;
  assign ev[B_ABRT] = raw.abort_cmd;
  assign ev[B_BFLT] = (raw.bad_addr | raw.tgt_abort) & raw.bus_master;
  assign ev[B_MPAR] = (raw.data_perr | raw.tgt_perr) & raw.par_chk_en;

  generate
    if (EXT_PAR) begin : g_xpar
      assign ev[B_XPAR] = raw.ext_perr;
    end else begin : g_no_xpar
      assign ev[B_XPAR] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_irq_settle.sv
module dma_irq_settle #(
  parameter int SETTLE = 12,
  localparam int CW = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  output logic          win,
  output logic          expire,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (rd) begin
      cnt_q <= CW'(SETTLE);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign win    = (cnt_q != '0);
  assign expire = (cnt_q == CW'(1)) && !rd;
endmodule

// File: rtl/dma_irq_stack.sv
module dma_irq_stack #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic         win,
  input  logic         expire,
  input  logic [N-1:0] ev,
  output logic [N-1:0] stat_d,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] pend_q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic s_d, p_d;
      always_comb begin
        s_d = stat_q[i];
        p_d = pend_q[i];
        if (rd) begin
          s_d = 1'b0;
          p_d = pend_q[i] | ev[i];
        end else if (expire) begin
          s_d = pend_q[i] | ev[i];
          p_d = 1'b0;
        end else if (win) begin
          p_d = pend_q[i] | ev[i];
        end else if (stat_q[i]) begin
          p_d = pend_q[i] | ev[i];
        end else begin
          s_d = ev[i];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          stat_q[i] <= 1'b0;
          pend_q[i] <= 1'b0;
        end else begin
          stat_q[i] <= s_d;
          pend_q[i] <= p_d;
        end
      end

      assign stat_d[i] = s_d;
    end
  endgenerate
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int SETTLE = 12,
  parameter bit EXT_PAR = 1'b1,
  localparam int DW = NSRC + 1,
  localparam int CW = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_empty_i,
  input  logic          data_perr_i,
  input  logic          tgt_perr_i,
  input  logic          par_chk_en_i,
  input  logic          bad_addr_i,
  input  logic          tgt_abort_i,
  input  logic          bus_master_i,
  input  logic          abort_cmd_i,
  input  logic          instr_done_i,
  input  logic          step_mode_i,
  input  logic          int_instr_i,
  input  logic          ext_perr_i,
  input  logic          bad_opcode_i,
  input  logic          zero_len_move_i,
  input  logic          wait_req_nodisc_i,
  input  logic          cmp_both_i,
  input  logic          target_mode_i,
  input  logic          ien_wr_i,
  input  logic [DW-1:0] ien_wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          pend_o
);
  raw_ev_t          raw;
  logic [NSRC-1:0]  ev;
  logic [NSRC-1:0]  stat_d, stat_q, pend_q;
  logic [DW-1:0]    ien_q, ien_d;
  logic             win, expire, any_d;
  logic [CW-1:0]    cnt_q;

  always_comb begin
    raw.data_perr       = data_perr_i;
    raw.tgt_perr        = tgt_perr_i;
    raw.par_chk_en      = par_chk_en_i;
    raw.bad_addr        = bad_addr_i;
    raw.tgt_abort       = tgt_abort_i;
    raw.bus_master      = bus_master_i;
    raw.abort_cmd       = abort_cmd_i;
    raw.instr_done      = instr_done_i;
    raw.step_mode       = step_mode_i;
    raw.int_instr       = int_instr_i;
    raw.ext_perr        = ext_perr_i;
    raw.bad_opcode      = bad_opcode_i;
    raw.zero_len_move   = zero_len_move_i;
    raw.wait_req_nodisc = wait_req_nodisc_i;
    raw.cmp_both        = cmp_both_i;
    raw.target_mode     = target_mode_i;
  end

  dma_irq_srcmap #(.EXT_PAR(EXT_PAR)) u_map (
    .raw (raw),
    .ev  (ev)
  );

  dma_irq_settle #(.SETTLE(SETTLE)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .rd     (rd_i),
    .win    (win),
    .expire (expire),
    .cnt_q  (cnt_q)
  );

  dma_irq_stack #(.N(NSRC)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .rd     (rd_i),
    .win    (win),
    .expire (expire),
    .ev     (ev),
    .stat_d (stat_d),
    .stat_q (stat_q),
    .pend_q (pend_q)
  );

  assign ien_d = ien_wr_i ? ien_wdata_i : ien_q;
  assign any_d = |(stat_d & ien_d[NSRC-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      rdata_o <= DW'(1) << NSRC;
      irq_o   <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      irq_o  <= any_d;
      pend_o <= (pend_o & ~rd_i) | any_d;
      if (rd_i) begin
        rdata_o <= {fifo_empty_i, stat_q};
      end
    end
  end
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int N = 7,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_i,
  input logic [N:0]    rdata_o,
  input logic          irq_o,
  input logic          pend_o,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  pend_q,
  input logic [N:0]    ien_q,
  input logic [CW-1:0] cnt_q
);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (stat_q == '0));

  a_r12_pend_cleared: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> !pend_o);

  a_r11_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(stat_q & ien_q[N-1:0]));

  a_r4_window_quiet: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > CW'(1)) |=> (stat_q == '0));

  a_r5_no_loss: assert property (@(posedge clk) disable iff (rst)
    !(cnt_q == CW'(1) && !rd_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

bind dma_irq_status dma_irq_chk #(.N(dma_irq_pkg::NSRC), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_o  (pend_o),
  .stat_q  (stat_q),
  .pend_q  (pend_q),
  .ien_q   (ien_q),
  .cnt_q   (cnt_q)
);

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_empty_i = 1'b0;
  logic data_perr_i = 0, tgt_perr_i = 0, par_chk_en_i = 1;
  logic bad_addr_i = 0, tgt_abort_i = 0, bus_master_i = 1;
  logic abort_cmd_i = 0, instr_done_i = 0, step_mode_i = 1;
  logic int_instr_i = 0, ext_perr_i = 0, bad_opcode_i = 0;
  logic zero_len_move_i = 0, wait_req_nodisc_i = 0, cmp_both_i = 0, target_mode_i = 1;
  logic ien_wr_i = 0;
  logic [7:0] ien_wdata_i = '0;
  logic rd_i = 0;
  logic [7:0] rdata_o;
  logic irq_o, pend_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_irq_status #(.SETTLE(SETTLE), .EXT_PAR(1'b1)) u0 (
    .clk(clk), .rst(rst), .fifo_empty_i(fifo_empty_i),
    .data_perr_i(data_perr_i), .tgt_perr_i(tgt_perr_i), .par_chk_en_i(par_chk_en_i),
    .bad_addr_i(bad_addr_i), .tgt_abort_i(tgt_abort_i), .bus_master_i(bus_master_i),
    .abort_cmd_i(abort_cmd_i), .instr_done_i(instr_done_i), .step_mode_i(step_mode_i),
    .int_instr_i(int_instr_i), .ext_perr_i(ext_perr_i), .bad_opcode_i(bad_opcode_i),
    .zero_len_move_i(zero_len_move_i), .wait_req_nodisc_i(wait_req_nodisc_i),
    .cmp_both_i(cmp_both_i), .target_mode_i(target_mode_i),
    .ien_wr_i(ien_wr_i), .ien_wdata_i(ien_wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .pend_o(pend_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // source index k -> raw input; expected bit given by src_bit
  task automatic set_raw(int k, logic v);
    case (k)
      0: bad_opcode_i = v;
      1: zero_len_move_i = v;
      2: wait_req_nodisc_i = v;
      3: cmp_both_i = v;
      4: ext_perr_i = v;
      5: int_instr_i = v;
      6: instr_done_i = v;
      7: abort_cmd_i = v;
      8: bad_addr_i = v;
      9: tgt_abort_i = v;
      10: data_perr_i = v;
      11: tgt_perr_i = v;
      default: ;
    endcase
  endtask

  function automatic int src_bit(int k);
    case (k)
      0, 1, 2, 3: return 0;
      4: return 1;
      5: return 2;
      6: return 3;
      7: return 4;
      8, 9: return 5;
      default: return 6;
    endcase
  endfunction

  // one raw source per status bit, used for patterns
  task automatic set_pattern(logic [6:0] p, logic v);
    if (p[0]) bad_opcode_i = v;
    if (p[1]) ext_perr_i = v;
    if (p[2]) int_instr_i = v;
    if (p[3]) instr_done_i = v;
    if (p[4]) abort_cmd_i = v;
    if (p[5]) bad_addr_i = v;
    if (p[6]) data_perr_i = v;
  endtask

  task automatic write_ien(logic [7:0] m);
    ien_wr_i = 1; ien_wdata_i = m;
    tick();
    ien_wr_i = 0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_i = 1;
    tick();
    rd_i = 0;
    v = rdata_o;
  endtask

  task automatic settle();
    repeat (SETTLE) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [6:0] p;
    logic [7:0] m;
    logic fe;

    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk("R1 rdata", rdata_o, 8'h80);
    chk("R1 irq", irq_o, 0);
    chk("R1 pend", pend_o, 0);

    // R2 bit 7 follows fifo level at the read
    fifo_empty_i = 1;
    do_read(v);
    chk("R2 fifo empty live", v, 8'h80);
    settle();
    fifo_empty_i = 0;
    do_read(v);
    chk("R2 fifo not empty", v, 8'h00);
    settle();

    write_ien(8'hFF);

    // R6 R7 R8 R9 R10 each source with qualifiers on
    for (int k = 0; k < 12; k++) begin
      set_raw(k, 1); tick(); set_raw(k, 0);
      chk($sformatf("R11 irq src %0d", k), irq_o, 1);
      do_read(v);
      chk($sformatf("R2 R9 R10 src %0d bit", k), v, 32'(1 << src_bit(k)));
      chk("R12 pend cleared by read", pend_o, 0);
      settle();
    end

    // qualifiers off: R6 R7 R8 R9 gating
    par_chk_en_i = 0; bus_master_i = 0; step_mode_i = 0; target_mode_i = 0;
    for (int k = 3; k < 12; k++) begin
      if (k == 4 || k == 5 || k == 7) continue;
      set_raw(k, 1); tick(); set_raw(k, 0);
      chk($sformatf("R6 R7 R8 R9 gated irq src %0d", k), irq_o, 0);
      do_read(v);
      chk($sformatf("R6 R7 R8 R9 gated src %0d", k), v, 0);
      settle();
    end
    par_chk_en_i = 1; bus_master_i = 1; step_mode_i = 1; target_mode_i = 1;

    // R3 read clears; immediate re-read is zero
    set_pattern(7'h55, 1); tick(); set_pattern(7'h55, 0);
    do_read(v);
    chk("R3 first read", v, 8'h55);
    do_read(v);
    chk("R3 second read zero", v, 8'h00);
    settle();

    // R5 stacked event on an already set bit
    int_instr_i = 1; tick(); int_instr_i = 0;
    int_instr_i = 1; tick(); int_instr_i = 0;
    do_read(v);
    chk("R5 first report", v, 8'h04);
    repeat (SETTLE - 1) tick();
    chk("R4 R5 still hidden", irq_o, 0);
    tick();
    chk("R4 R5 reloaded at window end", irq_o, 1);
    do_read(v);
    chk("R5 stacked report", v, 8'h04);
    settle();

    // R4 event inside window
    do_read(v);
    abort_cmd_i = 1; tick(); abort_cmd_i = 0;
    repeat (SETTLE - 2) tick();
    chk("R4 window event hidden", irq_o, 0);
    do_read(v);
    chk("R4 read in window", v, 8'h00);
    repeat (SETTLE - 1) tick();
    chk("R4 restarted window hidden", irq_o, 0);
    tick();
    chk("R4 window event visible", irq_o, 1);
    do_read(v);
    chk("R4 window event bit", v, 8'h10);
    settle();

    // R12 sticky summary after mask removed
    write_ien(8'h08);
    instr_done_i = 1; tick(); instr_done_i = 0;
    chk("R12 pend set", pend_o, 1);
    write_ien(8'h00);
    chk("R11 irq follows mask", irq_o, 0);
    chk("R12 pend sticky", pend_o, 1);
    do_read(v);
    chk("R12 pend cleared", pend_o, 0);
    chk("R8 step bit", v, 8'h08);
    settle();

    // R11 R2 sweep over masks and patterns
    for (int mi = 0; mi < 128; mi++) begin
      for (int q = 0; q < 8; q++) begin
        p = 7'((mi * 5 + q * 37 + 11) & 8'h7F);
        m = {q[1], 7'(mi)};
        fe = q[0];
        write_ien(m);
        set_pattern(p, 1); tick(); set_pattern(p, 0);
        chk("R11 sweep irq", irq_o, |(p & m[6:0]));
        chk("R12 sweep pend", pend_o, |(p & m[6:0]));
        fifo_empty_i = fe;
        do_read(v);
        chk("R2 sweep rdata", v, {fe, p});
        chk("R12 sweep pend clr", pend_o, 0);
        settle();
      end
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule